// File: doc/BRIEF.md
# Interrupt Request Pending Register

This block holds the pending interrupt requests of a small interrupt controller in one 8-bit register. Each of eight peripheral request lines sets its own pending bit. Software reaches the register over a simple register bus at one address. The bus offers three operations: a read, a plain write that replaces the contents, and an atomic OR-write. The OR-write merges a mask into the current value within a single cycle, so a hardware request that arrives at the same time is never lost. Because every bit can be written, software can also raise an interrupt by writing a 1.

When the global interrupt enable is high, any pending bit raises a registered request to the CPU. When the enable is low, no request goes out, and software finds pending work by reading the register. When the CPU services a source, it pulses an acknowledge that carries that source's index, and this clears the matching bit. A new set aimed at the same bit in the same cycle takes priority over the clear.

Top module: `irq_pend_reg`

## Requirements
- R1: After synchronous reset every pending bit is 0, `bus_rdata` is 0 and `cpu_irq` is 0.
- R2: A 1 on `hw_req[i]` sets pending bit i, and the bit stays set after the request line drops. The bit order is 7 timer 2, 6 timer 1, 5 timer 0, 4 UART0 receive, 3 UART0 transmit, 2 I2C, 1 SPI, 0 ADC.
- R3: A plain write (`bus_wr`) at address 0xFC0 replaces the pending bits with `bus_wdata`. This can clear bits as well as set them.
- R4: An OR-write (`bus_orw` with `bus_wr` low) at 0xFC0 makes the pending bits equal to their old value ORed with `bus_wdata`.
- R5: A plain write or an OR-write at any address other than 0xFC0 leaves the pending bits unchanged.
- R6: An acknowledge (`ack_vld`=1) with index `ack_idx`=i clears only pending bit i. When `ack_vld` is 0, the acknowledge has no effect.
- R7: If a hardware set or a software set (plain write or OR-write) targets a bit in the same cycle as an acknowledge of that bit, the bit ends up 1.
- R8: If a plain write and a hardware request occur in the same cycle, the pending bits become `bus_wdata | hw_req`.
- R9: `cpu_irq` is a register loaded each cycle with `glb_en` AND the OR of the pending bits as they stood before that edge. It is therefore 0 whenever `glb_en` was 0 in the previous cycle.
- R10: A read (`bus_rd`) at 0xFC0 returns the pending bits, as they stood before that edge, on `bus_rdata` one cycle later. In every other cycle `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | 8 | Peripheral request lines; a 1 sets the pending bit |
| bus_addr | input | 12 | Register bus address |
| bus_wr | input | 1 | Plain write strobe |
| bus_orw | input | 1 | OR-write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data or OR mask |
| bus_rdata | output | 8 | Registered read data |
| glb_en | input | 1 | Global interrupt enable |
| ack_vld | input | 1 | One-cycle CPU acknowledge pulse |
| ack_idx | input | 3 | Index of the source being acknowledged |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |

## Verification
The hardest situations to produce are the collisions within a single cycle. These are an acknowledge meeting a hardware set or a software set on the same bit, and a plain write meeting a hardware request. At the ports they are visible only through a later read. The stimulus drives each collision in one cycle and reads the register in the next, so the read shows the exact result of that one edge. The enable is also held low while bits are pending, and then raised, so that the gating and the one-cycle delay of the CPU request both show at the ports.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  parameter int NSRC = 8;

  typedef enum int {
    SRC_ADC   = 0,
    SRC_SPI   = 1,
    SRC_I2C   = 2,
    SRC_U0TX  = 3,
    SRC_U0RX  = 4,
    SRC_TMR0  = 5,
    SRC_TMR1  = 6,
    SRC_TMR2  = 7
  } irq_src_e;

  typedef struct packed {
    logic wr_hit;
    logic orw_hit;
    logic rd_hit;
  } bus_op_t;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_pend_pkg::*;
#(
  parameter int AW = 12,
  parameter logic [AW-1:0] BASE = 12'hFC0
) (
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_orw,
  input  logic          bus_rd,
  output bus_op_t       op
);
  logic hit;

  always_comb begin
    hit        = (bus_addr == BASE);
    op.wr_hit  = hit & bus_wr;
    op.orw_hit = hit & bus_orw & ~bus_wr;
    op.rd_hit  = hit & bus_rd;
  end
endmodule

// File: rtl/irq_pend_bits.sv
module irq_pend_bits
  import irq_pend_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     hw_req,
  input  bus_op_t          op,
  input  logic [N-1:0]     wdata,
  input  logic             ack_vld,
  input  logic [IDX_W-1:0] ack_idx,
  output logic [N-1:0]     pend
);
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_bit
      logic ack_hit;
      logic sw_set;
      logic base;
      logic nxt;

      always_comb begin
        ack_hit = ack_vld && (ack_idx == IDX_W'(gi));
        sw_set  = (op.wr_hit | op.orw_hit) & wdata[gi];
        base    = op.wr_hit ? wdata[gi] : pend[gi];
        nxt     = (base & ~ack_hit) | hw_req[gi] | sw_set;
      end

      always_ff @(posedge clk) begin
        if (rst) pend[gi] <= 1'b0;
        else     pend[gi] <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_cpu_req.sv
module irq_cpu_req #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend,
  input  logic         glb_en,
  output logic         cpu_irq
);
  always_ff @(posedge clk) begin
    if (rst) cpu_irq <= 1'b0;
    else     cpu_irq <= glb_en & (|pend);
  end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_pend_pkg::*;
#(
  parameter int N     = NSRC,
  parameter int IDX_W = $clog2(N),
  parameter int AW    = 12,
  parameter logic [AW-1:0] BASE = 12'hFC0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     hw_req,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_orw,
  input  logic             bus_rd,
  input  logic [N-1:0]     bus_wdata,
  output logic [N-1:0]     bus_rdata,
  input  logic             glb_en,
  input  logic             ack_vld,
  input  logic [IDX_W-1:0] ack_idx,
  output logic             cpu_irq
);
  bus_op_t      op;
  logic [N-1:0] pend;

  irq_bus_decode #(.AW(AW), .BASE(BASE)) u_dec (
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_orw(bus_orw),
    .bus_rd(bus_rd), .op(op)
  );

  irq_pend_bits #(.N(N), .IDX_W(IDX_W)) u_bits (
    .clk(clk), .rst(rst), .hw_req(hw_req), .op(op), .wdata(bus_wdata),
    .ack_vld(ack_vld), .ack_idx(ack_idx), .pend(pend)
  );

  irq_cpu_req #(.N(N)) u_req (
    .clk(clk), .rst(rst), .pend(pend), .glb_en(glb_en), .cpu_irq(cpu_irq)
  );

  always_ff @(posedge clk) begin
    if (rst)            bus_rdata <= '0;
    else if (op.rd_hit) bus_rdata <= pend;
    else                bus_rdata <= '0;
  end
endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk #(
  parameter int N     = 8,
  parameter int IDX_W = 3,
  parameter int AW    = 12,
  parameter logic [AW-1:0] BASE = 12'hFC0
) (
  input logic             clk,
  input logic             rst,
  input logic [N-1:0]     hw_req,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_wr,
  input logic             bus_orw,
  input logic             bus_rd,
  input logic [N-1:0]     bus_wdata,
  input logic [N-1:0]     bus_rdata,
  input logic             glb_en,
  input logic             ack_vld,
  input logic [IDX_W-1:0] ack_idx,
  input logic             cpu_irq
);
  logic at_base;
  assign at_base = (bus_addr == BASE);

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> !cpu_irq);

  assert_rd_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && at_base) |=> (bus_rdata == '0));

  assert_hw_sets_R2: assert property (@(posedge clk) disable iff (rst)
    ((hw_req != '0) && glb_en) ##1 glb_en |=> cpu_irq);

  assert_wr_merge_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && at_base) ##1 (bus_rd && at_base)
      |=> (bus_rdata == ($past(bus_wdata, 2) | $past(hw_req, 2))));

  assert_ack_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_vld && !hw_req[ack_idx] && !(at_base && (bus_wr || bus_orw)))
      ##1 (bus_rd && at_base)
      |=> !bus_rdata[$past(ack_idx, 2)]);
endmodule

bind irq_pend_reg irq_pend_chk #(.N(N), .IDX_W(IDX_W), .AW(AW), .BASE(BASE)) u_chk (
  .clk(clk), .rst(rst), .hw_req(hw_req), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_orw(bus_orw), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .glb_en(glb_en),
  .ack_vld(ack_vld), .ack_idx(ack_idx), .cpu_irq(cpu_irq)
);

// File: tb/irq_pend_reg_tb_top.sv
module irq_pend_reg_tb_top;
  localparam int N = 8;
  localparam logic [11:0] BASE = 12'hFC0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] hw_req = '0;
  logic [11:0]  bus_addr = '0;
  logic bus_wr = 0, bus_orw = 0, bus_rd = 0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic glb_en = 0, ack_vld = 0;
  logic [2:0] ack_idx = '0;
  logic cpu_irq;

  always #10 clk = ~clk;

  irq_pend_reg dut_i (
    .clk(clk), .rst(rst), .hw_req(hw_req), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_orw(bus_orw), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .glb_en(glb_en),
    .ack_vld(ack_vld), .ack_idx(ack_idx), .cpu_irq(cpu_irq)
  );

  typedef struct {
    string        tag;
    logic [N-1:0] rd;
    logic         irq;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  logic [N-1:0] model = '0;

  // staged stimulus for the next cycle
  logic [N-1:0] s_hw = '0, s_wd = '0;
  logic [11:0]  s_addr = BASE;
  logic s_rst = 0, s_wr = 0, s_orw = 0, s_rd = 0, s_en = 0, s_av = 0;
  logic [2:0] s_ai = '0;

  task automatic cyc(input string tag);
    exp_t e;
    logic [N-1:0] ackm, sw, base;
    @(negedge clk);
    rst = s_rst; hw_req = s_hw; bus_addr = s_addr; bus_wr = s_wr;
    bus_orw = s_orw; bus_rd = s_rd; bus_wdata = s_wd; glb_en = s_en;
    ack_vld = s_av; ack_idx = s_ai;
    @(posedge clk);
    e.tag = tag;
    if (s_rst) begin
      e.rd = '0; e.irq = 1'b0; model = '0;
    end else begin
      e.rd  = (s_rd && s_addr == BASE) ? model : '0;
      e.irq = s_en & (|model);
      ackm  = s_av ? (N'(1) << s_ai) : '0;
      sw    = (s_addr == BASE && (s_wr || s_orw)) ? s_wd : '0;
      base  = (s_addr == BASE && s_wr) ? s_wd : model;
      model = (base & ~ackm) | s_hw | sw;
    end
    exp_q.push_back(e);
    s_rst = 0; s_hw = '0; s_addr = BASE; s_wr = 0; s_orw = 0; s_rd = 0;
    s_wd = '0; s_av = 0; s_ai = '0;
  endtask

  task automatic rd(input string tag);
    s_rd = 1; cyc(tag);
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      n_cmp++;
      if (bus_rdata !== e.rd) begin
        n_bad++;
        $display("FAIL %s rdata actual %h expected %h", e.tag, bus_rdata, e.rd);
      end
      n_cmp++;
      if (cpu_irq !== e.irq) begin
        n_bad++;
        $display("FAIL %s cpu_irq actual %b expected %b", e.tag, cpu_irq, e.irq);
      end
    end
  end

  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 5000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    s_rst = 1; cyc("R1 reset");
    s_rst = 1; cyc("R1 reset");
    s_rst = 1; cyc("R1 reset");
    rd("R1 read after reset");
    // R2: hardware sets, held after line drops; enable low so R9 gate shows
    s_hw = 8'h80; cyc("R2 timer2 request");
    cyc("R2 idle");
    rd("R2 read timer2 pending");
    s_hw = 8'h01; cyc("R2 adc request");
    rd("R2 read two pending");
    // R3 plain write replaces
    s_wr = 1; s_wd = 8'h05; cyc("R3 plain write");
    rd("R3 read after write");
    // R4 OR-write merges
    s_orw = 1; s_wd = 8'h30; cyc("R4 or write");
    rd("R4 read after or write");
    // R5 other address ignored
    s_wr = 1; s_addr = 12'hFC1; s_wd = 8'hFF; cyc("R5 write other addr");
    s_orw = 1; s_addr = 12'h7C0; s_wd = 8'hFF; cyc("R5 or write other addr");
    rd("R5 read unchanged");
    s_rd = 1; s_addr = 12'hFC1; cyc("R10 read other addr");
    // R6 acknowledge clear
    s_av = 1; s_ai = 3'd4; cyc("R6 ack uart rx");
    rd("R6 read after ack");
    s_av = 0; s_ai = 3'd0; cyc("R6 ack_vld low");
    rd("R6 read no change");
    // R7 set beats ack
    s_av = 1; s_ai = 3'd0; s_hw = 8'h01; cyc("R7 hw set vs ack");
    rd("R7 read hw kept");
    s_av = 1; s_ai = 3'd2; s_orw = 1; s_wd = 8'h04; cyc("R7 sw set vs ack");
    rd("R7 read sw kept");
    // R8 plain write with hardware request
    s_wr = 1; s_wd = 8'h40; s_hw = 8'h02; cyc("R8 write plus hw");
    rd("R8 read merged");
    // R9 enable gating and delay
    s_en = 1; cyc("R9 enable on");
    cyc("R9 irq high");
    s_av = 1; s_ai = 3'd6; cyc("R9 ack one");
    s_av = 1; s_ai = 3'd1; cyc("R9 ack last");
    cyc("R9 irq drops");
    rd("R9 read empty");
    s_orw = 1; s_wd = 8'h08; cyc("R9 sw raise");
    cyc("R9 irq from sw");
    s_en = 0; cyc("R9 enable off");
    rd("R9 polled read");
    cyc("R10 idle rdata");
    @(negedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule